// File: doc/BRIEF.md
# Parallel-Bus DMA Engine with Per-Domain Timing Cost

This block copies a run of bytes between a local DRAM and an external parallel-bus address space, in either direction. Software loads a DRAM start address and a bus start address, then writes one of two length registers. The register written chooses the direction: one copies DRAM to bus, the other copies bus to DRAM. Both memories are reached through one shared byte-wide port. Each byte takes a read cycle on the source followed by a write cycle on the destination.

The bus is split into two timing domains. Each domain has four programmable timing fields: access latency, strobe pulse width, page size and release time. At the length write, the engine picks the domain from the bus address and works out a bus-cycle cost from that domain's fields. It scales the cost by 1.5 for the faster processor clock and holds its busy flag until the cost has elapsed and the copy has finished. Only then does it advance both address registers past the moved data and raise its interrupt. Software clears the interrupt through the status register.

Top module: `pbdma_top`

## Requirements
- R1: After reset, every register reads zero, including the two length registers, which always read zero. `busy`, `irq` and `mem_req` are low.
- R2: Timing fields sit at word offsets 0x14, 0x18, 0x1C and 0x20 for domain A (latency, pulse width, page exponent, release) and at 0x24, 0x28, 0x2C and 0x30 for domain B in the same order. Latency, pulse width and release keep the low 8 bits of the written value. The page exponent keeps the low 4 bits. Each field reads back what it holds.
- R3: The DRAM address register is at 0x00 and the bus address register at 0x04. A write to 0x08 starts a DRAM-to-bus copy and a write to 0x0C starts a bus-to-DRAM copy. In both cases the length L is the low 24 bits of the written value plus one. Byte i of the source lands at destination start + i.
- R4: At start, bit 0 of the bus address is cleared. The DRAM address is reduced to its low 23 bits, also with bit 0 cleared. Every DRAM access on the memory port has address bits 31:23 at zero.
- R5: When a transfer completes, the DRAM address register holds the reduced DRAM start plus L and the bus address register holds the aligned bus start plus L.
- R6: Bus addresses 0x05000000–0x05FFFFFF and 0x08000000–0x0FFFFFFF use domain B timing. Every other address, including 0x06000000–0x07FFFFFF and 0x10000000 upward, uses domain A timing.
- R7: Let the chosen domain have latency l, pulse width w, page exponent p and release r. Then P = ceil(L / 2^(p+2)), S = (l+20)·P + (w+r+2)·floor(L/2) and C = S + floor(S/2). `busy` rises on the clock edge that takes the length write and stays high for exactly max(C, 2·L)+1 cycles.
- R8: `irq` stays low when the length is written and rises on the edge where `busy` falls. Status register 0x10 shows busy in bit 0 and the pending interrupt in bit 1. Writing status with bit 1 set clears the interrupt.
- R9: A length write while `busy` is high is ignored. It changes neither the running transfer's duration, its length nor its final addresses.
- R10: `mem_req` is asserted only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory port access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_to_bus | output | 1 | 1 = bus space, 0 = DRAM |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid in the same cycle |
| irq | output | 1 | Transfer-complete interrupt |
| busy | output | 1 | Transfer pending |

## Verification
The copy-and-cost function is run in both directions and against both domains. One bus address falls in each decoded range, so a wrong domain choice shows up as a wrong busy length. Odd and out-of-range start addresses check the alignment and the 23-bit reduction. A length that is not a page multiple checks the rounding up. A long transfer with minimal timing makes the copy outlast the computed cost, which tells the max() rule apart from a plain cost countdown. A second length write in the middle of a transfer must leave the busy length, the bytes written and the final addresses unchanged.

// File: rtl/pbdma_pkg.sv
package pbdma_pkg;

    localparam int TIM_W = 8;
    localparam int PG_W  = 4;

    typedef struct packed {
        logic [TIM_W-1:0] lat;
        logic [TIM_W-1:0] pwd;
        logic [PG_W-1:0]  pgs;
        logic [TIM_W-1:0] rls;
    } bus_timing_t;

    typedef enum logic { DOM_A = 1'b0, DOM_B = 1'b1 } dom_e;

    typedef enum logic [1:0] { MV_IDLE, MV_RD, MV_WR } mv_phase_e;

    localparam logic [5:0] OFF_DRAM    = 6'h00;
    localparam logic [5:0] OFF_BUS     = 6'h04;
    localparam logic [5:0] OFF_LEN_OUT = 6'h08;
    localparam logic [5:0] OFF_LEN_IN  = 6'h0C;
    localparam logic [5:0] OFF_STAT    = 6'h10;
    localparam logic [5:0] OFF_TIM0    = 6'h14;
    localparam logic [5:0] TIM_STRIDE  = 6'h10;

    function automatic dom_e bus_domain(input logic [31:0] a);
        if ((a >= 32'h0500_0000 && a <= 32'h05FF_FFFF) ||
            (a >= 32'h0800_0000 && a <= 32'h0FFF_FFFF))
            return DOM_B;
        return DOM_A;
    endfunction

endpackage

// File: rtl/pbdma_domain_dec.sv
module pbdma_domain_dec
    import pbdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  bus_timing_t       tim_a,
    input  bus_timing_t       tim_b,
    output bus_timing_t       tim_sel
);
    dom_e dom;

    always_comb begin
        dom     = bus_domain(32'(bus_addr));
        tim_sel = (dom == DOM_B) ? tim_b : tim_a;
    end
endmodule

// File: rtl/pbdma_cost.sv
module pbdma_cost
    import pbdma_pkg::*;
#(
    parameter int LEN_W = 24,
    parameter int CNT_W = 40
) (
    input  bus_timing_t      tim,
    input  logic [LEN_W:0]   len,
    output logic [CNT_W-1:0] cost
);
    localparam int LW = LEN_W + 2;

    logic [4:0]       sh;
    logic [LW-1:0]    pg_m1;
    logic [LW-1:0]    pages;
    logic [CNT_W-1:0] per_page, per_half, sum;

    always_comb begin
        sh       = 5'(tim.pgs) + 5'd2;
        pg_m1    = (LW'(1) << sh) - LW'(1);
        pages    = (LW'(len) + pg_m1) >> sh;
        per_page = CNT_W'(tim.lat) + CNT_W'(20);
        per_half = CNT_W'(tim.pwd) + CNT_W'(tim.rls) + CNT_W'(2);
        sum      = per_page * CNT_W'(pages) + per_half * CNT_W'(len >> 1);
        cost     = sum + (sum >> 1);
    end
endmodule

// File: rtl/pbdma_mover.sv
module pbdma_mover
    import pbdma_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DRAM_AW = 23,
    parameter int LEN_W   = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              to_bus,
    input  logic [ADDR_W-1:0] dram_base,
    input  logic [ADDR_W-1:0] bus_base,
    input  logic [LEN_W:0]    len,
    input  logic [7:0]        mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_to_bus,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              done
);
    mv_phase_e         phase;
    logic [LEN_W:0]    idx;
    logic [7:0]        hold;
    logic [ADDR_W-1:0] dram_byte, bus_byte;
    logic              on_bus;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= MV_IDLE;
            idx   <= '0;
            hold  <= '0;
        end else if (start) begin
            phase <= MV_RD;
            idx   <= '0;
        end else begin
            case (phase)
                MV_RD: begin
                    hold  <= mem_rdata;
                    phase <= MV_WR;
                end
                MV_WR: begin
                    idx   <= idx + 1'b1;
                    phase <= (idx + 1'b1 == len) ? MV_IDLE : MV_RD;
                end
                default: phase <= MV_IDLE;
            endcase
        end
    end

    always_comb begin
        dram_byte  = ADDR_W'(dram_base[DRAM_AW-1:0] + idx[DRAM_AW-1:0]);
        bus_byte   = bus_base + ADDR_W'(idx);
        on_bus     = (phase == MV_WR) ? to_bus : !to_bus;
        mem_req    = (phase != MV_IDLE);
        mem_we     = (phase == MV_WR);
        mem_to_bus = on_bus;
        mem_addr   = on_bus ? bus_byte : dram_byte;
        mem_wdata  = hold;
        done       = (phase == MV_IDLE);
    end
endmodule

// File: rtl/pbdma_top.sv
module pbdma_top
    import pbdma_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DRAM_AW = 23,
    parameter int LEN_W   = 24,
    parameter int CNT_W   = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_to_bus,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              irq,
    output logic              busy
);
    localparam int NDOM = 2;
    localparam logic [ADDR_W-1:0] DRAM_MASK = ADDR_W'((64'(1) << DRAM_AW) - 2);

    logic [ADDR_W-1:0] dram_q, bus_q;
    bus_timing_t       tim_q [NDOM];
    logic              busy_q, irq_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] x_dram, x_bus;
    logic [LEN_W:0]    x_len;
    logic              x_to_bus;

    logic [ADDR_W-1:0] m_dram, m_bus;
    logic [LEN_W:0]    w_len;
    logic              len_wr, start, mv_done, finish;
    bus_timing_t       tim_sel;
    logic [CNT_W-1:0]  cost;

    always_comb begin
        m_dram = dram_q & DRAM_MASK;
        m_bus  = bus_q & ~ADDR_W'(1);
        w_len  = {1'b0, reg_wdata[LEN_W-1:0]} + 1'b1;
        len_wr = reg_we && (reg_addr == OFF_LEN_OUT || reg_addr == OFF_LEN_IN);
        start  = len_wr && !busy_q;
        finish = busy_q && (cnt_q == '0) && mv_done;
    end

    pbdma_domain_dec #(.ADDR_W(ADDR_W)) u_dec (
        .bus_addr(m_bus), .tim_a(tim_q[0]), .tim_b(tim_q[1]), .tim_sel(tim_sel)
    );

    pbdma_cost #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_cost (
        .tim(tim_sel), .len(w_len), .cost(cost)
    );

    pbdma_mover #(.ADDR_W(ADDR_W), .DRAM_AW(DRAM_AW), .LEN_W(LEN_W)) u_mover (
        .clk(clk), .rst(rst), .start(start), .to_bus(x_to_bus),
        .dram_base(x_dram), .bus_base(x_bus), .len(x_len),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_to_bus(mem_to_bus), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done(mv_done)
    );

    // Timing fields, one bank per domain
    for (genvar d = 0; d < NDOM; d++) begin : g_tim
        localparam logic [5:0] BASE = OFF_TIM0 + 6'(d) * TIM_STRIDE;
        always_ff @(posedge clk) begin
            if (rst) begin
                tim_q[d] <= '0;
            end else if (reg_we) begin
                if (reg_addr == BASE)         tim_q[d].lat <= reg_wdata[TIM_W-1:0];
                if (reg_addr == BASE + 6'h04) tim_q[d].pwd <= reg_wdata[TIM_W-1:0];
                if (reg_addr == BASE + 6'h08) tim_q[d].pgs <= reg_wdata[PG_W-1:0];
                if (reg_addr == BASE + 6'h0C) tim_q[d].rls <= reg_wdata[TIM_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dram_q   <= '0;
            bus_q    <= '0;
            busy_q   <= 1'b0;
            irq_q    <= 1'b0;
            cnt_q    <= '0;
            x_dram   <= '0;
            x_bus    <= '0;
            x_len    <= '0;
            x_to_bus <= 1'b0;
        end else begin
            if (reg_we && reg_addr == OFF_DRAM) dram_q <= reg_wdata;
            if (reg_we && reg_addr == OFF_BUS)  bus_q  <= reg_wdata;
            if (reg_we && reg_addr == OFF_STAT && reg_wdata[1]) irq_q <= 1'b0;
            if (start) begin
                busy_q   <= 1'b1;
                cnt_q    <= cost;
                x_dram   <= m_dram;
                x_bus    <= m_bus;
                x_len    <= w_len;
                x_to_bus <= (reg_addr == OFF_LEN_OUT);
            end else if (busy_q && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (finish) begin
                busy_q <= 1'b0;
                irq_q  <= 1'b1;
                dram_q <= x_dram + ADDR_W'(x_len);
                bus_q  <= x_bus + ADDR_W'(x_len);
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_DRAM: reg_rdata = 32'(dram_q);
            OFF_BUS:  reg_rdata = 32'(bus_q);
            OFF_STAT: reg_rdata = {30'd0, irq_q, busy_q};
            default: begin
                for (int d = 0; d < NDOM; d++) begin
                    if (reg_addr == OFF_TIM0 + 6'(d) * TIM_STRIDE)
                        reg_rdata = 32'(tim_q[d].lat);
                    if (reg_addr == OFF_TIM0 + 6'(d) * TIM_STRIDE + 6'h04)
                        reg_rdata = 32'(tim_q[d].pwd);
                    if (reg_addr == OFF_TIM0 + 6'(d) * TIM_STRIDE + 6'h08)
                        reg_rdata = 32'(tim_q[d].pgs);
                    if (reg_addr == OFF_TIM0 + 6'(d) * TIM_STRIDE + 6'h0C)
                        reg_rdata = 32'(tim_q[d].rls);
                end
            end
        endcase
    end

    assign irq  = irq_q;
    assign busy = busy_q;
endmodule

// File: rtl/pbdma_chk.sv
module pbdma_chk #(
    parameter int ADDR_W  = 32,
    parameter int DRAM_AW = 23
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              irq,
    input logic              mem_req,
    input logic              mem_to_bus,
    input logic [ADDR_W-1:0] mem_addr
);
    // R8: interrupt rises only on the completion edge
    a_r8_irq_on_done: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $fell(busy));

    // R8: completion always leaves the interrupt pending
    a_r8_done_sets_irq: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq);

    // R10: memory port idle outside a transfer
    a_r10_req_in_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R4: DRAM accesses stay inside the reduced address space
    a_r4_dram_range: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_to_bus) |-> (mem_addr >> DRAM_AW) == '0);
endmodule

bind pbdma_top pbdma_chk #(.ADDR_W(ADDR_W), .DRAM_AW(DRAM_AW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .irq(irq),
    .mem_req(mem_req), .mem_to_bus(mem_to_bus), .mem_addr(mem_addr)
);

// File: tb/pbdma_top_tb.sv
module pbdma_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_to_bus;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        irq, busy;

    logic [7:0]  dram_m [256];
    logic [7:0]  bus_m  [256];

    int n_checks = 0;
    int n_fail   = 0;
    int exp_q [$];
    int busy_cnt = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pbdma_top u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_to_bus(mem_to_bus), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq), .busy(busy)
    );

    assign mem_rdata = mem_to_bus ? bus_m[mem_addr[7:0]] : dram_m[mem_addr[7:0]];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) begin
                dram_m[i] <= 8'(i) ^ 8'h5A;
                bus_m[i]  <= 8'(i * 7 + 3);
            end
        end else if (mem_req && mem_we) begin
            if (mem_to_bus) bus_m[mem_addr[7:0]]  <= mem_wdata;
            else            dram_m[mem_addr[7:0]] <= mem_wdata;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: measures each busy window and compares with the queued expectation (R7)
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cnt++;
            else if (busy_cnt != 0) begin
                if (exp_q.size() == 0) check("R7 unexpected busy window", busy_cnt, 0);
                else check("R7 busy duration", busy_cnt, exp_q.pop_front());
                busy_cnt = 0;
            end
        end
    end

    function automatic int exp_busy(int lat, int pwd, int pg, int rls, int len);
        int psz = 1 << (pg + 2);
        int pages = (len + psz - 1) / psz;
        int s = (lat + 20) * pages + (pwd + rls + 2) * (len / 2);
        int c = s + s / 2;
        return ((c > 2 * len) ? c : 2 * len) + 1;
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    // Driver: program addresses, push expected busy length, start, finish
    task automatic xfer(input logic to_bus, input logic [31:0] dram_a, input logic [31:0] bus_a,
                        input logic [31:0] len_val, input int exp_n, input bit poke);
        logic [31:0] v;
        wr(6'h00, dram_a);
        wr(6'h04, bus_a);
        exp_q.push_back(exp_n);
        wr(to_bus ? 6'h08 : 6'h0C, len_val);
        check("R8 no irq at length write", {30'd0, irq, busy}, 32'h1);
        if (poke) begin
            repeat (5) @(negedge clk);
            wr(6'h0C, 32'd99);   // R9: must be ignored
            wr(6'h08, 32'd3);
        end
        wait_idle();
        check("R8 irq after completion", {31'd0, irq}, 32'h1);
        rd(6'h10, v);
        check("R8 status shows pending irq", v, 32'h2);
        wr(6'h10, 32'h2);
        check("R8 irq cleared by status write", {31'd0, irq}, 32'h0);
    endtask

    initial begin
        #(4 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  keep;
        bit ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 busy/irq/mem_req low", {29'd0, busy, irq, mem_req}, 32'h0);
        for (int a = 0; a <= 12; a++) begin
            rd(6'(a * 4), v);
            check("R1 register reset value", v, 32'h0);
        end

        // R2: field widths and placement
        wr(6'h14, 32'hFFFF_FFFF); rd(6'h14, v); check("R2 lat width", v, 32'hFF);
        wr(6'h1C, 32'hFFFF_FFF7); rd(6'h1C, v); check("R2 page width", v, 32'h7);
        rd(6'h2C, v); check("R2 domain B untouched", v, 32'h0);
        wr(6'h14, 32'd3); wr(6'h18, 32'd5); wr(6'h1C, 32'd0); wr(6'h20, 32'd2);
        wr(6'h24, 32'd10); wr(6'h28, 32'd1); wr(6'h2C, 32'd2); wr(6'h30, 32'd0);
        rd(6'h18, v); check("R2 A pulse", v, 32'd5);
        rd(6'h20, v); check("R2 A release", v, 32'd2);
        rd(6'h24, v); check("R2 B latency", v, 32'd10);
        rd(6'h2C, v); check("R2 B page", v, 32'd2);

        // Case A: bus->DRAM, domain A range 0x06.., L=16, with mid-transfer length writes (R9)
        keep = dram_m[8'h50];
        xfer(1'b0, 32'h0000_0040, 32'h0600_0010, 32'd15, exp_busy(3, 5, 0, 2, 16), 1'b1);
        ok = 1;
        for (int i = 0; i < 16; i++) if (dram_m[8'h40 + i] !== bus_m[8'h10 + i]) ok = 0;
        check("R3 bus to DRAM bytes", {31'd0, ok}, 32'h1);
        check("R9 no byte past L", {24'd0, dram_m[8'h50]}, {24'd0, keep});
        rd(6'h00, v); check("R5 R9 DRAM addr advance", v, 32'h50);
        rd(6'h04, v); check("R5 R9 bus addr advance", v, 32'h0600_0020);

        // Case B: DRAM->bus, domain B, odd/out-of-range addresses, upper length bits ignored
        keep = bus_m[8'h0A];
        xfer(1'b1, 32'hFF80_0083, 32'h0800_0101, 32'hAB00_0009, exp_busy(10, 1, 2, 0, 10), 1'b0);
        ok = 1;
        for (int i = 0; i < 10; i++) if (bus_m[i] !== dram_m[8'h82 + i]) ok = 0;
        check("R3 R4 DRAM to bus bytes", {31'd0, ok}, 32'h1);
        check("R3 length field", {24'd0, bus_m[8'h0A]}, {24'd0, keep});
        rd(6'h00, v); check("R4 R5 DRAM addr reduced+L", v, 32'h0000_008C);
        rd(6'h04, v); check("R4 R5 bus addr aligned+L", v, 32'h0800_010A);

        // Case C: domain B lower range (R6)
        xfer(1'b0, 32'h0000_0010, 32'h0500_0020, 32'd7, exp_busy(10, 1, 2, 0, 8), 1'b0);
        ok = 1;
        for (int i = 0; i < 8; i++) if (dram_m[8'h10 + i] !== bus_m[8'h20 + i]) ok = 0;
        check("R6 domain B low range copy", {31'd0, ok}, 32'h1);

        // Case E: page rounding, L=18 over 4-byte pages, domain A
        xfer(1'b1, 32'h0000_00A0, 32'h0600_0040, 32'd17, exp_busy(3, 5, 0, 2, 18), 1'b0);
        rd(6'h04, v); check("R7 R5 bus addr after rounding case", v, 32'h0600_0052);

        // Case D: domain A upper range, minimal timing so copy outlasts cost (R7 max)
        wr(6'h14, 32'd0); wr(6'h18, 32'd0); wr(6'h1C, 32'd15); wr(6'h20, 32'd0);
        xfer(1'b0, 32'h0000_0000, 32'h1000_0030, 32'd99, exp_busy(0, 0, 15, 0, 100), 1'b0);
        ok = 1;
        for (int i = 0; i < 100; i++) if (dram_m[i] !== bus_m[8'h30 + i]) ok = 0;
        check("R6 R3 domain A upper range copy", {31'd0, ok}, 32'h1);
        check("R10 port idle after transfer", {31'd0, mem_req}, 32'h0);

        repeat (3) @(negedge clk);
        check("R7 all busy windows measured", exp_q.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule